// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Burst Address Counters

This block is a two-port synchronous memory of 2^AW words of 18 bits. It defaults to 4K words, and AW = 13 gives 8K. Each port has its own clock and reset. Each port registers its address, controls and write data on its own rising clock edge. Either port may read or write any word while the other does the same.

Each port's address register also works as a burst counter. In a cycle it can do one of four things:
- clear to zero;
- load from the external address;
- step up by one and wrap at the top of the array;
- otherwise, follow the external address directly.

With stepping, a port can stream successive words without presenting new addresses.

A shared mode input selects the read path. In flow-through mode, read data appears right after the address edge. In pipelined mode, read data passes through one more output register. Two chip selects, one active low and one active high, deselect a port. A deselected port drives its valid flag low and its data output to zero.

Top module: `dual_port_burst_ram`

## Requirements
- R1: Each port can write any word, and a word written by one port can be read back by the other port. If both ports write the same word in the same cycle, the result is undefined.
- R2: A write happens in a cycle where the port is selected and rw_n is 0. In that cycle, lane[0] enables bits 8:0 and lane[1] enables bits 17:9. A bit whose lane is disabled keeps its old value.
- R3: When flow is 1, read data and valid appear after the same edge that captures the address. When flow is 0, they appear one cycle later.
- R4: A port whose load input is 1 (and zero is 0) sets its address counter to the external address.
- R5: A port whose step input is 1 (and load and zero are 0) increments its counter by one. The external address is ignored in that cycle.
- R6: Stepping from the last word (all ones) wraps the counter to word 0.
- R7: When zero is 1, the counter is cleared to 0, whatever load and step are.
- R8: A port is selected when sel_n is 0 and sel is 1. While a port is deselected, its writes have no effect, and it shows valid 0 and data 0. In pipelined mode, valid returns only one cycle after the first selected read.
- R9: When load, step and zero are all 0, the captured address is the external address.
- R10: After reset, q is 0 and vld is 0 on both ports, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flow | input | 1 | 1: flow-through reads, 0: pipelined reads |
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A async reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_rw_n | input | 1 | Port A 1 = read, 0 = write |
| a_lane | input | 2 | Port A byte-lane write enables |
| a_addr | input | AW | Port A external address |
| a_din | input | 18 | Port A write data |
| a_load | input | 1 | Port A counter load |
| a_step | input | 1 | Port A counter increment |
| a_zero | input | 1 | Port A counter clear |
| a_q | output | 18 | Port A read data |
| a_vld | output | 1 | Port A read data valid |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B async reset, active low |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_rw_n | input | 1 | Port B 1 = read, 0 = write |
| b_lane | input | 2 | Port B byte-lane write enables |
| b_addr | input | AW | Port B external address |
| b_din | input | 18 | Port B write data |
| b_load | input | 1 | Port B counter load |
| b_step | input | 1 | Port B counter increment |
| b_zero | input | 1 | Port B counter clear |
| b_q | output | 18 | Port B read data |
| b_vld | output | 1 | Port B read data valid |

## Verification
The counter wrap is the hardest case to reach. The counter is not visible at the ports, and reaching the top word by stepping alone would take thousands of cycles.

The stimulus first writes distinct marker values into the last word and into word 0. It then loads the counter with the all-ones address and steps once. Each marker shows up on the flow-through output exactly when the counter sits on its word.

The pipelined reactivation after a deselect is checked cycle by cycle. Deselected, selected-first and selected-second reads follow each other directly.

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram #(
  parameter int AW = 12,
  parameter int LANE = 9,
  localparam int W = 2 * LANE
) (
  input  logic          flow,
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_sel_n,
  input  logic          a_sel,
  input  logic          a_rw_n,
  input  logic [1:0]    a_lane,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_din,
  input  logic          a_load,
  input  logic          a_step,
  input  logic          a_zero,
  output logic [W-1:0]  a_q,
  output logic          a_vld,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_sel_n,
  input  logic          b_sel,
  input  logic          b_rw_n,
  input  logic [1:0]    b_lane,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_din,
  input  logic          b_load,
  input  logic          b_step,
  input  logic          b_zero,
  output logic [W-1:0]  b_q,
  output logic          b_vld
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = 1;
  localparam logic [AW-1:0] TOP = '1;

  // Each port owns one bank; a word's value is the XOR of both banks.
  logic [W-1:0] bank_a [DEPTH];
  logic [W-1:0] bank_b [DEPTH];

  // ---------------- port A ----------------
  logic [AW-1:0] a_ctr;
  logic          a_on, a_wr;
  logic [1:0]    a_ln;
  logic [W-1:0]  a_d, a_qp;
  logic          a_vp;

  always_ff @(posedge a_clk or negedge a_rst_n)
    if (!a_rst_n) begin
      a_ctr <= '0; a_on <= 1'b0; a_wr <= 1'b0; a_ln <= '0; a_d <= '0;
    end else begin
      a_on <= !a_sel_n && a_sel;
      a_wr <= !a_rw_n;
      a_ln <= a_lane;
      a_d  <= a_din;
      if (a_zero)      a_ctr <= '0;
      else if (a_load) a_ctr <= a_addr;
      else if (a_step) a_ctr <= a_ctr + ONE;
      else             a_ctr <= a_addr;
    end

  wire [W-1:0] a_old = bank_a[a_ctr] ^ bank_b[a_ctr];
  wire [W-1:0] a_new = {a_ln[1] ? a_d[W-1:LANE] : a_old[W-1:LANE],
                        a_ln[0] ? a_d[LANE-1:0] : a_old[LANE-1:0]};
  wire         a_rd  = a_on && !a_wr;

  always_ff @(posedge a_clk)
    if (a_on && a_wr) bank_a[a_ctr] <= a_new ^ bank_b[a_ctr];

  always_ff @(posedge a_clk or negedge a_rst_n)
    if (!a_rst_n) begin
      a_vp <= 1'b0; a_qp <= '0;
    end else begin
      a_vp <= a_rd;
      a_qp <= a_rd ? a_old : '0;
    end

  assign a_vld = flow ? a_rd : a_vp;
  assign a_q   = flow ? (a_rd ? a_old : '0) : a_qp;

  // R4
  a_load_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_load && !a_zero |=> a_ctr == $past(a_addr));
  // R5
  a_step_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_step && !a_load && !a_zero |=> a_ctr == $past(a_ctr) + ONE);
  // R6
  a_wrap_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_step && !a_load && !a_zero && a_ctr == TOP |=> a_ctr == '0);
  // R7
  a_zero_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_zero |=> a_ctr == '0);
  // R8
  a_desel_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    !flow && !a_on |=> flow || (!a_vld && a_q == '0));

  // ---------------- port B ----------------
  logic [AW-1:0] b_ctr;
  logic          b_on, b_wr;
  logic [1:0]    b_ln;
  logic [W-1:0]  b_d, b_qp;
  logic          b_vp;

  always_ff @(posedge b_clk or negedge b_rst_n)
    if (!b_rst_n) begin
      b_ctr <= '0; b_on <= 1'b0; b_wr <= 1'b0; b_ln <= '0; b_d <= '0;
    end else begin
      b_on <= !b_sel_n && b_sel;
      b_wr <= !b_rw_n;
      b_ln <= b_lane;
      b_d  <= b_din;
      if (b_zero)      b_ctr <= '0;
      else if (b_load) b_ctr <= b_addr;
      else if (b_step) b_ctr <= b_ctr + ONE;
      else             b_ctr <= b_addr;
    end

  wire [W-1:0] b_old = bank_a[b_ctr] ^ bank_b[b_ctr];
  wire [W-1:0] b_new = {b_ln[1] ? b_d[W-1:LANE] : b_old[W-1:LANE],
                        b_ln[0] ? b_d[LANE-1:0] : b_old[LANE-1:0]};
  wire         b_rd  = b_on && !b_wr;

  always_ff @(posedge b_clk)
    if (b_on && b_wr) bank_b[b_ctr] <= b_new ^ bank_a[b_ctr];

  always_ff @(posedge b_clk or negedge b_rst_n)
    if (!b_rst_n) begin
      b_vp <= 1'b0; b_qp <= '0;
    end else begin
      b_vp <= b_rd;
      b_qp <= b_rd ? b_old : '0;
    end

  assign b_vld = flow ? b_rd : b_vp;
  assign b_q   = flow ? (b_rd ? b_old : '0) : b_qp;

  // R4
  b_load_chk: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    b_load && !b_zero |=> b_ctr == $past(b_addr));
  // R7
  b_zero_chk: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    b_zero |=> b_ctr == '0);
  // R8
  b_desel_chk: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    !flow && !b_on |=> flow || (!b_vld && b_q == '0));
endmodule

// File: tb/dual_port_burst_ram_test.sv
module dual_port_burst_ram_test;
  localparam int AW = 12;
  localparam int W = 18;

  logic flow = 1'b1;
  logic a_clk = 1'b0, b_clk = 1'b0, a_rst_n = 1'b0, b_rst_n = 1'b0;
  logic a_sel_n = 1'b1, a_sel = 1'b0, a_rw_n = 1'b1, a_load = 1'b0, a_step = 1'b0, a_zero = 1'b0;
  logic b_sel_n = 1'b1, b_sel = 1'b0, b_rw_n = 1'b1, b_load = 1'b0, b_step = 1'b0, b_zero = 1'b0;
  logic [1:0] a_lane = '0, b_lane = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_q, b_q;
  logic a_vld, b_vld;
  int checks = 0, errors = 0;

  always #5 a_clk = ~a_clk;
  always #5 b_clk = ~b_clk;

  dual_port_burst_ram #(.AW(AW)) uut (
    .flow(flow),
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_sel_n(a_sel_n), .a_sel(a_sel), .a_rw_n(a_rw_n),
    .a_lane(a_lane), .a_addr(a_addr), .a_din(a_din), .a_load(a_load), .a_step(a_step),
    .a_zero(a_zero), .a_q(a_q), .a_vld(a_vld),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_sel_n(b_sel_n), .b_sel(b_sel), .b_rw_n(b_rw_n),
    .b_lane(b_lane), .b_addr(b_addr), .b_din(b_din), .b_load(b_load), .b_step(b_step),
    .b_zero(b_zero), .b_q(b_q), .b_vld(b_vld));

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic a_go(input logic sn, input logic s, input logic rwn, input logic [1:0] ln,
                      input logic [AW-1:0] ad, input logic [W-1:0] d,
                      input logic ld, input logic st, input logic zr);
    @(negedge a_clk);
    a_sel_n = sn; a_sel = s; a_rw_n = rwn; a_lane = ln; a_addr = ad; a_din = d;
    a_load = ld; a_step = st; a_zero = zr;
    @(posedge a_clk); #2;
  endtask

  task automatic b_go(input logic sn, input logic s, input logic rwn, input logic [1:0] ln,
                      input logic [AW-1:0] ad, input logic [W-1:0] d,
                      input logic ld, input logic st, input logic zr);
    @(negedge b_clk);
    b_sel_n = sn; b_sel = s; b_rw_n = rwn; b_lane = ln; b_addr = ad; b_din = d;
    b_load = ld; b_step = st; b_zero = zr;
    @(posedge b_clk); #2;
  endtask

  task automatic a_wr(input logic [AW-1:0] ad, input logic [W-1:0] d);
    a_go(1'b0, 1'b1, 1'b0, 2'b11, ad, d, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic a_rd(input logic [AW-1:0] ad);
    a_go(1'b0, 1'b1, 1'b1, 2'b00, ad, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R10 a_q", a_q, '0);
    chk("R10 a_vld", W'(a_vld), '0);
    chk("R10 b_q", b_q, '0);
    chk("R10 b_vld", W'(b_vld), '0);
  endtask

  task automatic t_flow;
    flow = 1'b1;
    a_wr(12'd5, 18'h01234);
    a_rd(12'd5);
    chk("R3 flow vld", W'(a_vld), 18'd1);
    chk("R9 R3 flow data", a_q, 18'h01234);
  endtask

  task automatic t_cross;
    b_go(1'b0, 1'b1, 1'b1, 2'b00, 12'd5, '0, 1'b0, 1'b0, 1'b0);
    chk("R1 B reads A", b_q, 18'h01234);
    b_go(1'b0, 1'b1, 1'b0, 2'b11, 12'd6, 18'h2ABCD, 1'b0, 1'b0, 1'b0);
    b_go(1'b0, 1'b1, 1'b1, 2'b00, 12'd6, '0, 1'b0, 1'b0, 1'b0);
    a_rd(12'd6);
    chk("R1 A reads B", a_q, 18'h2ABCD);
  endtask

  task automatic t_pipe;
    flow = 1'b0;
    a_wr(12'd7, 18'h15555);
    a_rd(12'd7);
    chk("R3 pipe no early vld", W'(a_vld), '0);
    a_rd(12'd8);
    chk("R3 pipe vld", W'(a_vld), 18'd1);
    chk("R3 pipe data", a_q, 18'h15555);
    flow = 1'b1;
  endtask

  task automatic t_lanes;
    a_wr(12'd9, 18'h3FFFF);
    a_go(1'b0, 1'b1, 1'b0, 2'b01, 12'd9, 18'h00000, 1'b0, 1'b0, 1'b0);
    a_rd(12'd9);
    chk("R2 low lane", a_q, 18'h3FE00);
    a_go(1'b0, 1'b1, 1'b0, 2'b10, 12'd9, 18'h00000, 1'b0, 1'b0, 1'b0);
    a_rd(12'd9);
    chk("R2 high lane", a_q, 18'h00000);
  endtask

  task automatic t_burst;
    a_go(1'b0, 1'b1, 1'b0, 2'b11, 12'd100, 18'h00011, 1'b1, 1'b0, 1'b0);
    a_go(1'b0, 1'b1, 1'b0, 2'b11, 12'd500, 18'h00022, 1'b0, 1'b1, 1'b0);
    a_go(1'b0, 1'b1, 1'b0, 2'b11, 12'd500, 18'h00033, 1'b0, 1'b1, 1'b0);
    a_rd(12'd100);
    chk("R4 burst word0", a_q, 18'h00011);
    a_rd(12'd101);
    chk("R5 burst word1", a_q, 18'h00022);
    a_rd(12'd102);
    chk("R5 burst word2", a_q, 18'h00033);
    a_go(1'b0, 1'b1, 1'b1, 2'b00, 12'd100, '0, 1'b1, 1'b0, 1'b0);
    chk("R4 load read", a_q, 18'h00011);
    a_go(1'b0, 1'b1, 1'b1, 2'b00, 12'd7, '0, 1'b0, 1'b1, 1'b0);
    chk("R5 step ignores addr", a_q, 18'h00022);
  endtask

  task automatic t_wrap;
    a_wr(12'hFFF, 18'h1F0F0);
    a_wr(12'h000, 18'h00ABC);
    a_go(1'b0, 1'b1, 1'b1, 2'b00, 12'hFFF, '0, 1'b1, 1'b0, 1'b0);
    chk("R6 top word", a_q, 18'h1F0F0);
    a_go(1'b0, 1'b1, 1'b1, 2'b00, 12'hFFF, '0, 1'b0, 1'b1, 1'b0);
    chk("R6 wrap to 0", a_q, 18'h00ABC);
  endtask

  task automatic t_zero;
    a_go(1'b0, 1'b1, 1'b1, 2'b00, 12'hFFF, '0, 1'b1, 1'b1, 1'b1);
    chk("R7 zero beats load", a_q, 18'h00ABC);
  endtask

  task automatic t_desel;
    flow = 1'b1;
    a_go(1'b1, 1'b1, 1'b0, 2'b11, 12'd5, 18'h0BEEF, 1'b0, 1'b0, 1'b0);
    chk("R8 sel_n high vld", W'(a_vld), '0);
    chk("R8 sel_n high q", a_q, '0);
    a_go(1'b0, 1'b0, 1'b0, 2'b11, 12'd5, 18'h0BEEF, 1'b0, 1'b0, 1'b0);
    chk("R8 sel low q", a_q, '0);
    a_rd(12'd5);
    chk("R8 write ignored", a_q, 18'h01234);
    b_go(1'b1, 1'b1, 1'b1, 2'b00, 12'd5, '0, 1'b0, 1'b0, 1'b0);
    chk("R8 B deselected", W'(b_vld), '0);
    flow = 1'b0;
    a_go(1'b1, 1'b1, 1'b1, 2'b00, 12'd5, '0, 1'b0, 1'b0, 1'b0);
    a_rd(12'd5);
    chk("R8 pipe first selected vld", W'(a_vld), '0);
    a_rd(12'd5);
    chk("R8 pipe back vld", W'(a_vld), 18'd1);
    chk("R8 pipe back data", a_q, 18'h01234);
    flow = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog all requirements got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge a_clk);
    #2;
    t_reset;
    @(negedge a_clk);
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    t_flow;
    t_cross;
    t_pipe;
    t_lanes;
    t_burst;
    t_wrap;
    t_zero;
    t_desel;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule